// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block collects eight single-cycle or level event indications from a serial bus controller and records each one in a sticky status register. Software sees which events occurred by reading that register and acknowledges them by writing ones to the matching bit positions. A per-source enable mask and a single master enable decide whether the recorded events drive the shared interrupt line toward the processor.

The same register window holds a keyed soft-reset location. Writing the exact key word clears all interrupt state in this block and emits a one-cycle reset pulse, which the rest of the controller uses to return to its idle state. Any other value written there is discarded. Reads are combinational from the stored registers. Unmapped addresses read as zero and ignore writes.

Top module: `intr_hub`

## Requirements
- R1: When `event_in[i]` is high in a cycle, status bit i is 1 from the following clock edge on. The status register reads at address 0x20 in bits 7:0, and bits 31:8 read 0. The bit meanings by position are: 0 arbitration lost, 1 transmit error or done, 2 transmit empty, 3 receive threshold reached, 4 bus idle, 5 addressed as target, 6 no longer addressed as target, 7 transmit half empty.
- R2: A status bit stays 1 until software writes address 0x20 with a 1 in that bit position. A 0 written to a bit position leaves that bit unchanged.
- R3: If an event and a clear write for the same bit fall in the same cycle, the bit stays 1.
- R4: The enable mask is read and written at address 0x28 in bits 7:0. Bits 31:8 read 0.
- R5: The master enable is bit 31 of address 0x1C. The other bits of that address read 0 and writes to them have no effect.
- R6: `irq` is 1 exactly when the master enable is 1 and at least one bit of (status AND enable mask) is 1. It follows the registers in the same cycle they change.
- R7: A write of 0x0000000A to address 0x40 clears status, enable mask and master enable at that clock edge, and this takes precedence over events in the same cycle. `soft_rst` is then high for exactly the one following cycle.
- R8: A write of any other value to address 0x40 produces no `soft_rst` pulse and changes no register. Address 0x40 reads 0.
- R9: After `rst_n` reset, every register reads 0, and `irq` and `soft_rst` are 0.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle high |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| event_in | input | N_SRC (8) | Event indications from the controller |
| irq | output | 1 | Interrupt request line |
| soft_rst | output | 1 | One-cycle controller reset pulse |

## Verification
The latching path is tried with single-bit events at both ends of the vector and with a mixed multi-bit pattern. This separates a wrong bit order or a dropped bit from a correct OR-in. Clear writes are tried with a partial mask, with an all-zero mask, and in the same cycle as an event on the same bit. These cases show that clearing acts per bit and that events win. The interrupt line is stepped through master-enable off with a masked match, then on, then the match removed by a clear and by the mask. The soft-reset location gets a near-miss key and a zero word before the real key, and the real key arrives together with a full event burst.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int N_SRC   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int GIE_POS = 31;

    // Byte offsets inside the register window
    localparam logic [7:0] OFS_GIE  = 8'h1C;
    localparam logic [7:0] OFS_STAT = 8'h20;
    localparam logic [7:0] OFS_EN   = 8'h28;
    localparam logic [7:0] OFS_KEY  = 8'h40;

    // Exact word that triggers the controller reset
    localparam logic [31:0] RESET_KEY = 32'h0000_000A;

    typedef struct packed {
        logic gie;
        logic stat;
        logic en;
        logic key;
    } reg_sel_t;
endpackage

// File: rtl/intr_decode.sv
module intr_decode
    import intr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output reg_sel_t          sel,
    output reg_sel_t          wr,
    output logic              key_fire
);
    always_comb begin
        sel.gie  = (addr == ADDR_W'(OFS_GIE));
        sel.stat = (addr == ADDR_W'(OFS_STAT));
        sel.en   = (addr == ADDR_W'(OFS_EN));
        sel.key  = (addr == ADDR_W'(OFS_KEY));
        wr       = we ? sel : '0;
        key_fire = wr.key && (wdata == DATA_W'(RESET_KEY));
    end
endmodule

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         wipe,
    output logic [N-1:0] stat_q
);
    typedef struct packed {
        logic [N-1:0] bits;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] nxt;

    // One latch cell per source; a new event outranks the acknowledge
    for (genvar i = 0; i < N; i++) begin : g_cell
        assign nxt[i] = !wipe && (ev[i] || (st_q.bits[i] && !(clr_we && clr_mask[i])));
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.bits;
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs #(
    parameter int N       = 8,
    parameter int DATA_W  = 32,
    parameter int GIE_POS = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en_we,
    input  logic              gie_we,
    input  logic              wipe,
    output logic [N-1:0]      en_q,
    output logic              gie_q
);
    typedef struct packed {
        logic [N-1:0] en;
        logic         gie;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (en_we)  m_d.en  = wdata[N-1:0];
        if (gie_we) m_d.gie = wdata[GIE_POS];
        if (wipe)   m_d     = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign en_q  = m_q.en;
    assign gie_q = m_q.gie;
endmodule

// File: rtl/intr_reset_key.sv
module intr_reset_key (
    input  logic clk,
    input  logic rst_n,
    input  logic key_fire,
    output logic pulse_q
);
    typedef struct packed {
        logic pulse;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d       = k_q;
        k_d.pulse = key_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign pulse_q = k_q.pulse;
endmodule

// File: rtl/intr_hub.sv
module intr_hub
    import intr_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int GIE_POS = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  event_in,
    output logic              irq,
    output logic              soft_rst
);
    localparam int PAD_W = DATA_W - N_SRC;

    reg_sel_t          sel, wr;
    logic              key_fire;
    logic [N_SRC-1:0]  stat_q;
    logic [N_SRC-1:0]  en_q;
    logic              gie_q;

    intr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .we       (reg_we),
        .sel      (sel),
        .wr       (wr),
        .key_fire (key_fire)
    );

    intr_status_bank #(.N(N_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (event_in),
        .clr_we   (wr.stat),
        .clr_mask (reg_wdata[N_SRC-1:0]),
        .wipe     (key_fire),
        .stat_q   (stat_q)
    );

    intr_mask_regs #(.N(N_SRC), .DATA_W(DATA_W), .GIE_POS(GIE_POS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (reg_wdata),
        .en_we  (wr.en),
        .gie_we (wr.gie),
        .wipe   (key_fire),
        .en_q   (en_q),
        .gie_q  (gie_q)
    );

    intr_reset_key u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_fire (key_fire),
        .pulse_q  (soft_rst)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel.stat) reg_rdata = {{PAD_W{1'b0}}, stat_q};
        if (sel.en)   reg_rdata = {{PAD_W{1'b0}}, en_q};
        if (sel.gie)  reg_rdata = DATA_W'(gie_q) << GIE_POS;
    end

    assign irq = gie_q && (|(stat_q & en_q));
endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk
    import intr_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [N_SRC-1:0]  event_in,
    input logic              irq,
    input logic              soft_rst,
    input logic [N_SRC-1:0]  stat_q,
    input logic [N_SRC-1:0]  en_q,
    input logic              gie_q
);
    logic             key_wr;
    logic [N_SRC-1:0] keep;

    assign key_wr = reg_we && (reg_addr == ADDR_W'(OFS_KEY)) && (reg_wdata == DATA_W'(RESET_KEY));
    assign keep   = stat_q & ~((reg_we && reg_addr == ADDR_W'(OFS_STAT)) ? reg_wdata[N_SRC-1:0] : '0);

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> ((stat_q & $past(event_in)) == $past(event_in)));  // R1
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> ((stat_q & ~$past(stat_q) & ~$past(event_in)) == '0));  // R1
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> (($past(keep) & ~stat_q) == '0));  // R2
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie_q);  // R6
    AST_KEY_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (stat_q == '0 && en_q == '0 && !gie_q && !irq));  // R7
    AST_KEY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> soft_rst);  // R7
    AST_PULSE_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> !soft_rst);  // R8
endmodule

bind intr_hub intr_hub_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .event_in  (event_in),
    .irq       (irq),
    .soft_rst  (soft_rst),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .gie_q     (gie_q)
);

// File: tb/intr_hub_test.sv
module intr_hub_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  event_in = '0;
    logic        irq;
    logic        soft_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    intr_hub uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .event_in  (event_in),
        .irq       (irq),
        .soft_rst  (soft_rst)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        reg_we   = 1'b0;
        #1;
        d = reg_rdata;
    endtask

    // Drive at a falling edge, commit at the rising edge, return at the next falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d, logic [7:0] ev);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        event_in  = ev;
        @(negedge clk);
        reg_we    = 1'b0;
        event_in  = '0;
    endtask

    task automatic fire(logic [7:0] ev);
        @(negedge clk);
        event_in = ev;
        @(negedge clk);
        event_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h1C, d); chk("R9 gie after reset", d, 32'h0);
        rd(8'h20, d); chk("R9 status after reset", d, 32'h0);
        rd(8'h28, d); chk("R9 enable after reset", d, 32'h0);
        rd(8'h40, d); chk("R8 key reads zero", d, 32'h0);
        rd(8'h04, d); chk("R10 unmapped read", d, 32'h0);
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);
        chk("R9 soft_rst after reset", {31'b0, soft_rst}, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        fire(8'h01); rd(8'h20, d); chk("R1 bit0 latched", d, 32'h01);
        fire(8'h80); rd(8'h20, d); chk("R1 bit7 ORed in", d, 32'h81);
        chk("R6 irq low while masked", {31'b0, irq}, 32'h0);
        wr(8'h20, 32'hFF, 8'h00); rd(8'h20, d); chk("R2 clear all", d, 32'h0);
        fire(8'h5A); rd(8'h20, d); chk("R1 mixed pattern", d, 32'h5A);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rd(8'h20, d); chk("R2 holds while idle", d, 32'h5A);
        wr(8'h20, 32'h02, 8'h00); rd(8'h20, d); chk("R2 partial clear", d, 32'h58);
        wr(8'h20, 32'h00, 8'h00); rd(8'h20, d); chk("R2 zero write no effect", d, 32'h58);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(8'h20, 32'h08, 8'h08); rd(8'h20, d); chk("R3 event beats clear", d, 32'h58);
        wr(8'h20, 32'h10, 8'h01); rd(8'h20, d); chk("R3 clear one, set other", d, 32'h49);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        wr(8'h28, 32'hFFFF_FF21, 8'h00); rd(8'h28, d); chk("R4 enable upper bits zero", d, 32'h21);
        wr(8'h1C, 32'h7FFF_FFFF, 8'h00); rd(8'h1C, d); chk("R5 only bit31 kept", d, 32'h0);
        chk("R6 irq off without gie", {31'b0, irq}, 32'h0);
        wr(8'h1C, 32'h8000_0000, 8'h00); rd(8'h1C, d); chk("R5 gie set", d, 32'h8000_0000);
        chk("R6 irq on with pending", {31'b0, irq}, 32'h1);
        wr(8'h20, 32'h01, 8'h00);
        chk("R6 irq drops after clear", {31'b0, irq}, 32'h0);
        fire(8'h20);
        chk("R6 irq from bit5", {31'b0, irq}, 32'h1);
        wr(8'h28, 32'h0, 8'h00);
        chk("R6 irq drops when masked", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_FFFF, 8'h00);
        rd(8'h30, d); chk("R10 unmapped reads zero", d, 32'h0);
        rd(8'h20, d); chk("R10 status untouched", d, 32'h68);
        rd(8'h28, d); chk("R10 enable untouched", d, 32'h0);
    endtask

    task automatic t_badkey();
        logic [31:0] d;
        wr(8'h28, 32'h20, 8'h00);
        wr(8'h40, 32'h1A, 8'h00);
        chk("R8 no pulse on near key", {31'b0, soft_rst}, 32'h0);
        wr(8'h40, 32'h0, 8'h00);
        chk("R8 no pulse on zero", {31'b0, soft_rst}, 32'h0);
        rd(8'h20, d); chk("R8 status kept", d, 32'h68);
        rd(8'h28, d); chk("R8 enable kept", d, 32'h20);
        rd(8'h1C, d); chk("R8 gie kept", d, 32'h8000_0000);
        chk("R8 irq kept", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_key();
        logic [31:0] d;
        wr(8'h40, 32'h0000_000A, 8'hFF);
        chk("R7 pulse after key", {31'b0, soft_rst}, 32'h1);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h20, d); chk("R7 status wiped despite events", d, 32'h0);
        rd(8'h28, d); chk("R7 enable wiped", d, 32'h0);
        rd(8'h1C, d); chk("R7 gie wiped", d, 32'h0);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'b0, soft_rst}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_sticky();
        t_collide();
        t_masks();
        t_unmapped();
        t_badkey();
        t_key();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule